// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous request port and an external asynchronous static RAM that has 512K sixteen-bit words and a separate strobe for each byte. A single-beat read or write is handed over with a valid/ready handshake. The controller then runs the memory pins through a fixed sequence of phases: one setup cycle, the access phase, recovery and, after a read only, a bus turnaround. The length of each phase is a parameter. It is derived from a nanosecond figure and the clock period, rounded up to whole cycles.

The request address, the write data, the 2-bit byte mask and the direction are latched when the request is accepted. They drive the pins until the cycle has finished, so the memory address never moves while the chip is selected. A write lowers the write enable for a counted pulse while output enable stays high. Lane strobes are lowered only for the bytes in the mask, and the write data is driven from the setup cycle until one cycle after the write enable rises. A read lowers output enable and captures the bus on its last cycle. Lanes that were not selected are returned as zero, and the result comes back with a one-cycle valid pulse. After a read the controller keeps its own data drivers off for a recovery cycle plus the turnaround count. This leaves the memory time to release the bus.

With the default parameters (10 ns clock, 55 ns read cycle, 55 ns write cycle, 45 ns write pulse, 20 ns bus release) the read access is 6 cycles, the write pulse is 5 cycles, write recovery is 1 cycle and turnaround is 2 cycles.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While rst_n is low, req_ready, rsp_valid and mem_dq_oe are low, mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n and mem_ub_n are high, and mem_ce2 is low. This takes effect as soon as rst_n falls, even in the middle of a cycle. req_ready is high again within a few cycles of rst_n rising.
- R2: req_ready is high only while the controller is idle. A request is taken at a rising clock edge where req_valid and req_ready are both high. req_ready is low from the next cycle until the memory cycle ends, and a request held during that time is taken only once ready returns.
- R3: mem_ce_n is low exactly when mem_ce2 is high. Both are active from the setup cycle through the access phase, and for writes also through recovery.
- R4: In a write, mem_we_n is low for exactly 5 consecutive cycles (WP_CYC), starting in cycle 2 after acceptance, and mem_oe_n stays high. Mask bit 0 selects bits 7:0 (mem_lb_n) and mask bit 1 selects bits 15:8 (mem_ub_n). A lane strobe is low during the pulse if and only if its mask bit is 1.
- R5: mem_addr changes only at an edge that ends a cycle in which mem_ce_n was high. It equals the accepted address whenever the chip is selected.
- R6: During a write, mem_dq_oe is high and mem_dq_out carries the accepted data from the setup cycle through the cycle after mem_we_n rises.
- R7: In a read, mem_oe_n is low for exactly 6 cycles (RD_CYC) and mem_we_n stays high. rsp_valid is high for exactly one cycle, cycle 8 after acceptance, which is the cycle in which mem_oe_n rises. rsp_rdata holds the bus as sampled in the last low cycle of mem_oe_n, with lanes whose mask bit is 0 forced to zero.
- R8: After a read, mem_dq_oe stays low through recovery and TA_CYC = 2 turnaround cycles. A write held pending behind a read first drives the bus 4 cycles after mem_oe_n rises.
- R9: Cycle 1 is the cycle after the accepting edge. req_ready is high again in cycle 8 after a write and in cycle 11 after a read.
- R10: With an all-zero mask, no lane strobe goes low. A write still runs its full timing but changes no stored byte, and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Lane select, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 19 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Second chip enable, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Strobe for bits 7:0, active low |
| mem_ub_n | output | 1 | Strobe for bits 15:8, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the controller's bus drivers |
| mem_dq_in | input | 16 | Data from the memory bus |

## Verification
The end of a read and the start of a pending write compete for the bus in the same few cycles. The memory may still drive the bus after output enable rises, while a write waiting at the request port wants to turn on the controller's drivers as early as possible. The bench provokes this by holding a write request valid for the whole of a read. Its memory model counts any cycle in which mem_dq_oe is high while the model is driving, or during the model's two-cycle release window. The bench also checks the exact distance from the rise of output enable to the first driven cycle, and it reads the written word back.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  localparam int SRAMC_DW    = 16;
  localparam int SRAMC_LANES = SRAMC_DW / 8;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_ACCESS  = 3'd2,
    ST_RECOVER = 3'd3,
    ST_TURN    = 3'd4
  } sramc_state_e;

  // Round a nanosecond figure up to whole clock cycles, never below one.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sramc_fsm.sv
module sramc_fsm
  import sramc_pkg::*;
#(
  parameter int RD_CYC  = 6,
  parameter int WP_CYC  = 5,
  parameter int REC_CYC = 1,
  parameter int TA_CYC  = 2,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             op_wr,
  input  logic             tmr_done,
  output logic             req_ready,
  output logic             accept,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             capture,
  output sramc_state_e     state_q
);

  sramc_state_e state_d;
  logic         rdy_q;
  logic         rdy_d;

  assign accept    = req_valid & rdy_q;
  assign req_ready = rdy_q;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) state_d = ST_SETUP;
      end
      ST_SETUP: begin
        state_d  = ST_ACCESS;
        tmr_load = 1'b1;
        tmr_val  = op_wr ? CNT_W'(WP_CYC - 1) : CNT_W'(RD_CYC - 1);
      end
      ST_ACCESS: begin
        if (tmr_done) begin
          state_d  = ST_RECOVER;
          tmr_load = 1'b1;
          tmr_val  = op_wr ? CNT_W'(REC_CYC - 1) : '0;
        end
      end
      ST_RECOVER: begin
        if (tmr_done) begin
          if (op_wr) begin
            state_d = ST_IDLE;
          end else begin
            state_d  = ST_TURN;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(TA_CYC - 1);
          end
        end
      end
      ST_TURN: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign rdy_d   = (state_d == ST_IDLE);
  assign capture = (state_q == ST_ACCESS) & ~op_wr & tmr_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rdy_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rdy_q   <= rdy_d;
    end
  end

endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath #(
  parameter int ADDR_W = 19,
  parameter int DW     = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [LANES-1:0]  req_bmask,
  input  logic              capture,
  input  logic [DW-1:0]     dq_in,
  output logic              op_wr,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DW-1:0]     op_wdata,
  output logic [LANES-1:0]  op_mask,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata
);

  logic [DW-1:0] lane_rd;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_rd[g*8 +: 8] = op_mask[g] ? dq_in[g*8 +: 8] : 8'h00;
    end
  endgenerate

  // Request latch: held unchanged for the whole memory cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_wr    <= 1'b0;
      op_addr  <= '0;
      op_wdata <= '0;
      op_mask  <= '0;
    end else if (accept) begin
      op_wr    <= req_write;
      op_addr  <= req_addr;
      op_wdata <= req_wdata;
      op_mask  <= req_bmask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
    end else if (capture) begin
      rsp_rdata <= lane_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= capture;
    end
  end

endmodule

// File: rtl/sramc_pins.sv
module sramc_pins
  import sramc_pkg::*;
#(
  parameter int LANES = 2
) (
  input  sramc_state_e      state_q,
  input  logic              op_wr,
  input  logic [LANES-1:0]  op_mask,
  output logic              ce_n,
  output logic              ce2,
  output logic              oe_n,
  output logic              we_n,
  output logic [LANES-1:0]  bs_n,
  output logic              dq_oe
);

  logic in_access;
  logic selected;
  logic wr_window;

  always_comb begin
    in_access = (state_q == ST_ACCESS);
    wr_window = op_wr & ((state_q == ST_SETUP) | in_access | (state_q == ST_RECOVER));
    selected  = (state_q == ST_SETUP) | in_access | (op_wr & (state_q == ST_RECOVER));
    ce_n      = ~selected;
    ce2       = selected;
    oe_n      = ~(in_access & ~op_wr);
    we_n      = ~(in_access & op_wr);
    dq_oe     = wr_window;
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_strobe
      assign bs_n[g] = ~(in_access & op_mask[g]);
    end
  endgenerate

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sramc_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int CLK_NS      = 10,
  parameter int T_RC_NS     = 55,
  parameter int T_WC_NS     = 55,
  parameter int T_WP_NS     = 45,
  parameter int T_BUSREL_NS = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [SRAMC_DW-1:0] req_wdata,
  input  logic [1:0]          req_bmask,
  output logic                rsp_valid,
  output logic [SRAMC_DW-1:0] rsp_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_ce_n,
  output logic                mem_ce2,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic                mem_lb_n,
  output logic                mem_ub_n,
  output logic [SRAMC_DW-1:0] mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [SRAMC_DW-1:0] mem_dq_in
);

  localparam int RD_CYC  = ns_to_cyc(T_RC_NS, CLK_NS);
  localparam int WP_CYC  = ns_to_cyc(T_WP_NS, CLK_NS);
  localparam int WC_CYC  = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int TA_CYC  = ns_to_cyc(T_BUSREL_NS, CLK_NS);
  localparam int REC_RAW = WC_CYC - WP_CYC - 1;
  localparam int REC_CYC = (REC_RAW < 1) ? 1 : REC_RAW;
  localparam int MAX_AB  = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int MAX_CD  = (REC_CYC > TA_CYC) ? REC_CYC : TA_CYC;
  localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  sramc_state_e           state_q;
  logic                   accept;
  logic                   tmr_load;
  logic [CNT_W-1:0]       tmr_val;
  logic                   tmr_done;
  logic                   capture;
  logic                   op_wr;
  logic [SRAMC_LANES-1:0] op_mask;
  logic [SRAMC_LANES-1:0] bs_n;

  sramc_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sramc_fsm #(
    .RD_CYC  (RD_CYC),
    .WP_CYC  (WP_CYC),
    .REC_CYC (REC_CYC),
    .TA_CYC  (TA_CYC),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .op_wr     (op_wr),
    .tmr_done  (tmr_done),
    .req_ready (req_ready),
    .accept    (accept),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .capture   (capture),
    .state_q   (state_q)
  );

  sramc_datapath #(
    .ADDR_W (ADDR_W),
    .DW     (SRAMC_DW),
    .LANES  (SRAMC_LANES)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .accept    (accept),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_bmask (req_bmask),
    .capture   (capture),
    .dq_in     (mem_dq_in),
    .op_wr     (op_wr),
    .op_addr   (mem_addr),
    .op_wdata  (mem_dq_out),
    .op_mask   (op_mask),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  sramc_pins #(
    .LANES (SRAMC_LANES)
  ) u_pins (
    .state_q (state_q),
    .op_wr   (op_wr),
    .op_mask (op_mask),
    .ce_n    (mem_ce_n),
    .ce2     (mem_ce2),
    .oe_n    (mem_oe_n),
    .we_n    (mem_we_n),
    .bs_n    (bs_n),
    .dq_oe   (mem_dq_oe)
  );

  assign mem_lb_n = bs_n[0];
  assign mem_ub_n = bs_n[1];

endmodule

// File: rtl/sramc_chk.sv
module sramc_chk #(
  parameter int ADDR_W = 19,
  parameter int DW     = 16,
  parameter int WP_CYC = 5,
  parameter int TA_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_ce2,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic [DW-1:0]     mem_dq_out,
  input logic              mem_dq_oe
);

  localparam int WL_W  = $clog2(WP_CYC + 2);
  localparam int WL_MX = (1 << WL_W) - 1;
  localparam int SR_MX = TA_CYC + 3;
  localparam int SR_W  = $clog2(SR_MX + 1);

  logic [WL_W-1:0] wlen_q;
  logic [SR_W-1:0] since_rd_q;

  // Length of the current write-enable low pulse, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlen_q <= '0;
    end else if (!mem_we_n) begin
      if (wlen_q != WL_W'(WL_MX)) wlen_q <= wlen_q + 1'b1;
    end else begin
      wlen_q <= '0;
    end
  end

  // Cycles since output enable was last low, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rd_q <= SR_W'(SR_MX);
    end else if (!mem_oe_n) begin
      since_rd_q <= '0;
    end else if (since_rd_q != SR_W'(SR_MX)) begin
      since_rd_q <= since_rd_q + 1'b1;
    end
  end

  // R3
  ce_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n == !mem_ce2);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  // R2
  rdy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R4
  wp_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wlen_q == WL_W'(WP_CYC)));

  // R4
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  // R4
  strobe_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_lb_n || !mem_ub_n) |-> !mem_ce_n);

  // R5
  addr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> $past(mem_ce_n));

  // R6
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_out)));

  // R7
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R7
  rvalid_at_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(mem_oe_n));

  // R8
  bus_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (since_rd_q >= SR_W'(TA_CYC + 1)));

endmodule

bind sram_cycle_ctrl sramc_chk #(
  .ADDR_W (ADDR_W),
  .DW     (sramc_pkg::SRAMC_DW),
  .WP_CYC (WP_CYC),
  .TA_CYC (TA_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_ce2    (mem_ce2),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_lb_n   (mem_lb_n),
  .mem_ub_n   (mem_ub_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sim_sram_cycle_ctrl.sv
module sim_sram_cycle_ctrl;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic [1:0]  mask;
    logic [18:0] addr;
    logic [15:0] wdata;
    logic [15:0] exp;
  } vec_t;

  localparam int NOPS = 12;
  localparam vec_t OPS [NOPS] = '{
    '{1'b1, 2'b11, 19'h00010, 16'h1234, 16'h0000},
    '{1'b0, 2'b11, 19'h00010, 16'h0000, 16'h1234},
    '{1'b1, 2'b01, 19'h00010, 16'hABCD, 16'h0000},
    '{1'b0, 2'b11, 19'h00010, 16'h0000, 16'h12CD},
    '{1'b1, 2'b10, 19'h00010, 16'h77EE, 16'h0000},
    '{1'b0, 2'b10, 19'h00010, 16'h0000, 16'h7700},
    '{1'b0, 2'b01, 19'h00010, 16'h0000, 16'h00CD},
    '{1'b1, 2'b00, 19'h00010, 16'hFFFF, 16'h0000},
    '{1'b0, 2'b11, 19'h00010, 16'h0000, 16'h77CD},
    '{1'b1, 2'b11, 19'h7FF21, 16'h5A5A, 16'h0000},
    '{1'b0, 2'b11, 19'h7FF21, 16'h0000, 16'h5A5A},
    '{1'b0, 2'b00, 19'h7FF21, 16'h0000, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_bmask = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
  logic [15:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_in;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_cycle_ctrl u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_bmask  (req_bmask),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_ce2    (mem_ce2),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_lb_n   (mem_lb_n),
    .mem_ub_n   (mem_ub_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_in  (mem_dq_in)
  );

  // Behavioural memory: 256 words indexed by the low address byte.
  logic [15:0] mem_m [256];
  logic [7:0]  m_idx;
  logic        m_rd;
  int          addr_viol = 0;
  int          contention = 0;
  int          wr_float = 0;
  int          hold = 0;
  bit          prev_sel = 1'b0;
  logic [18:0] prev_addr = '0;

  assign m_idx = mem_addr[7:0];
  assign m_rd  = !mem_ce_n && mem_ce2 && !mem_oe_n && mem_we_n;
  assign mem_dq_in = {(m_rd && !mem_ub_n) ? mem_m[m_idx][15:8] : 8'hA5,
                      (m_rd && !mem_lb_n) ? mem_m[m_idx][7:0]  : 8'hA5};

  initial begin
    for (int i = 0; i < 256; i++) mem_m[i] = 16'h0000;
  end

  always @(negedge clk) begin
    bit sel;
    bit wr_act;
    sel    = !mem_ce_n && mem_ce2;
    wr_act = sel && !mem_we_n && (!mem_lb_n || !mem_ub_n);
    if (sel && prev_sel && (mem_addr !== prev_addr)) addr_viol++;
    if (mem_dq_oe && (m_rd || hold > 0)) contention++;
    if (wr_act && !mem_dq_oe) wr_float++;
    if (wr_act && !mem_lb_n) mem_m[m_idx][7:0]  = mem_dq_out[7:0];
    if (wr_act && !mem_ub_n) mem_m[m_idx][15:8] = mem_dq_out[15:8];
    if (m_rd) hold = 2;
    else if (hold > 0) hold = hold - 1;
    prev_sel  = sel;
    prev_addr = mem_addr;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_req(input vec_t v);
    req_valid = 1'b1;
    req_write = v.wr;
    req_addr  = v.addr;
    req_wdata = v.wdata;
    req_bmask = v.mask;
  endtask

  task automatic run_op(input vec_t v);
    int wlo = 0, olo = 0, vcnt = 0, vat = -1, done_at = -1;
    int addr_bad = 0, bs_bad = 0;
    bit hold_ok = 1'b1;
    logic [15:0] got = '0;
    @(negedge clk);
    drive_req(v);
    check(req_ready == 1'b1, "R2 ready before request", 32'(req_ready), 32'h1);
    @(posedge clk);
    for (int c = 0; c < 24; c++) begin
      @(negedge clk);
      if (c == 0) req_valid = 1'b0;
      if (!mem_ce_n && mem_addr !== v.addr) addr_bad++;
      if ((!mem_we_n || !mem_oe_n) && ({mem_ub_n, mem_lb_n} !== ~v.mask)) bs_bad++;
      if (!mem_we_n) wlo++;
      if (!mem_oe_n) olo++;
      if (rsp_valid) begin vcnt++; vat = c; got = rsp_rdata; end
      if (v.wr && c == 6) hold_ok = mem_dq_oe && (mem_dq_out == v.wdata) && mem_we_n;
      if (req_ready) begin done_at = c; break; end
    end
    check(addr_bad == 0, "R5 address during select", 32'(addr_bad), 32'h0);
    check(bs_bad == 0, "R4/R10 lane strobes vs mask", 32'(bs_bad), 32'h0);
    if (v.wr) begin
      check(wlo == 5, "R4 write pulse cycles", 32'(wlo), 32'd5);
      check(olo == 0, "R4 output enable during write", 32'(olo), 32'h0);
      check(hold_ok, "R6 data held after write enable rises", 32'(hold_ok), 32'h1);
      check(vcnt == 0, "R7 no valid on write", 32'(vcnt), 32'h0);
      check(done_at == 7, "R9 write ready cycle", 32'(done_at + 1), 32'd8);
    end else begin
      check(olo == 6, "R7 output enable cycles", 32'(olo), 32'd6);
      check(wlo == 0, "R7 write enable during read", 32'(wlo), 32'h0);
      check(vcnt == 1 && vat == 7, "R7 valid pulse cycle", 32'(vat + 1), 32'd8);
      check(got == v.exp, "R7/R10 read data", 32'(got), 32'(v.exp));
      check(done_at == 10, "R9 read ready cycle", 32'(done_at + 1), 32'd11);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: state while reset is held
    repeat (3) @(negedge clk);
    check(req_ready == 1'b0, "R1 ready in reset", 32'(req_ready), 32'h0);
    check({mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe, rsp_valid}
          == 8'b10111100, "R1 pins in reset",
          32'({mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe, rsp_valid}),
          32'b10111100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after release", 32'(req_ready), 32'h1);
    check(mem_ce_n && !mem_ce2 && !mem_dq_oe, "R1 idle deselected",
          32'({mem_ce_n, mem_ce2, mem_dq_oe}), 32'b100);

    // Vector table
    for (int i = 0; i < NOPS; i++) run_op(OPS[i]);

    // R8 / R2: write held valid across a read
    begin
      int oe_rise = -1, dq_rise = -1, acc_at = -1;
      bit seen_lo = 1'b0;
      logic [15:0] got = '0;
      vec_t rd = '{1'b0, 2'b11, 19'h00010, 16'h0000, 16'h77CD};
      vec_t wr = '{1'b1, 2'b11, 19'h00033, 16'hC3C3, 16'h0000};
      @(negedge clk);
      drive_req(rd);
      @(posedge clk);
      for (int c = 0; c < 21; c++) begin
        @(negedge clk);
        if (c == 0) drive_req(wr);
        if (acc_at >= 0 && c == acc_at + 1) req_valid = 1'b0;
        if (!mem_oe_n) seen_lo = 1'b1;
        if (seen_lo && mem_oe_n && oe_rise < 0) oe_rise = c;
        if (mem_dq_oe && dq_rise < 0) dq_rise = c;
        if (rsp_valid) got = rsp_rdata;
        if (req_ready && acc_at < 0) acc_at = c;
      end
      check(dq_rise - oe_rise == 4, "R8 bus turnaround gap", 32'(dq_rise - oe_rise), 32'd4);
      check(acc_at == 10, "R2 held write taken when ready", 32'(acc_at + 1), 32'd11);
      check(got == 16'h77CD, "R7 read before held write", 32'(got), 32'h77CD);
      check(contention == 0, "R8 bus contention with memory", 32'(contention), 32'h0);
      run_op('{1'b0, 2'b11, 19'h00033, 16'h0000, 16'hC3C3});
    end

    // R1: reset asserted in the middle of a write
    @(negedge clk);
    drive_req('{1'b1, 2'b11, 19'h00044, 16'h9999, 16'h0000});
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check(mem_we_n == 1'b0, "R4 write pulse under way", 32'(mem_we_n), 32'h0);
    rst_n = 1'b0;
    #1;
    check({mem_ce_n, mem_ce2, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ready} == 7'b1011100,
          "R1 immediate reset mid-write",
          32'({mem_ce_n, mem_ce2, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ready}),
          32'b1011100);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after second release", 32'(req_ready), 32'h1);

    check(addr_viol == 0, "R5 address moved while selected", 32'(addr_viol), 32'h0);
    check(wr_float == 0, "R6 undriven bus during write", 32'(wr_float), 32'h0);
    check(contention == 0, "R8 contention over whole run", 32'(contention), 32'h0);
    // R3 checked through ce_pair_chk and the select checks above.

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule